// File: doc/BRIEF.md
# Video Receive Colour-Plane Adapter with Register Bank

This block sits between the clocked-video output of a video link receiver and the input of a clocked-video capture stage. It carries pixel beats and their sync flags through one register stage. While doing so it rearranges the three colour planes of every pixel from the order used on the link into the order the processing pipeline expects. The choice of order follows the colour-space field of the AVI InfoFrame currently received. That choice is taken once per frame, at its first active pixel, so a frame never switches order partway through.

Alongside the video path, the block offers a small word-addressed register bank to a control processor. Through it the processor reads the received General Control Packet and the InfoFrame bytes (the checksum is kept out of view), the TMDS clock-ratio flag and the transceiver-busy flag. It also drives the receive transceiver reset, the reconfiguration enable and the reconfiguration channel number.

The video stream is qualified by a valid strobe. It carries no ready signal, because a clocked-video source cannot be held off. Every beat with valid high is taken in and re-emitted exactly one cycle later. Beats with valid low are carried through in the same way, with their valid still low. The downstream stage must accept every output beat.

Top module: `vrx_adapter`

## Requirements
- R1: Output valid, data-enable, hsync, vsync and pixel data equal the corresponding inputs from exactly one clock earlier. No beat is dropped, added or stalled.
- R2: When the InfoFrame colour-space field (vector bits [14:13], which are bits [6:5] of data byte 1) is 00 (RGB), each pixel's lanes 0,1,2 (BPC bits each, lane 0 lowest, pixel 0 lowest) go out as input lanes 1,0,2. This turns link order G,B,R into B,G,R, and it applies to every pixel in the beat.
- R3: When the colour-space field is 01, 10 or 11, pixel data goes out unchanged.
- R4: The plane order is taken from the colour-space field on the first beat with valid and data-enable high after reset, or after a valid beat with vsync high. It is then held for every later beat until the next such frame start, so a change of the field mid-frame has no effect on the current frame.
- R5: Word 0 (byte address 0) reads the received General Control Packet, zero-extended.
- R6: Word n, for n from 1 to 13, reads InfoFrame bits [8n+7:8n] in bits [7:0], with the upper bits zero. The checksum bits [7:0] are returned by no word.
- R7: Word 14 bit 0 reads the TMDS clock-ratio flag. Word 15 reads zero. Word 16 bit 0 reads the transceiver-busy flag.
- R8: Word 17 bit 0 drives the transceiver reset, word 18 bit 0 drives the reconfiguration enable, and word 19 bits [CHAN_W-1:0] drive the reconfiguration channel. Each is written from the write data, reads back its value, and is 0 after reset.
- R9: Register n sits at byte address 4n, and the two low address bits are ignored. Writes to words other than 17 to 19 change nothing. Reads of words 20 and above return zero.
- R10: A read strobe loads the read data on the next clock edge. The read data holds its value while no read is strobed, and it is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the video path and the register bank |
| rst | input | 1 | Synchronous reset, active high |
| cv_in_valid | input | 1 | Input beat qualifier |
| cv_in_de | input | 1 | Input active-picture flag |
| cv_in_hsync | input | 1 | Input horizontal sync |
| cv_in_vsync | input | 1 | Input vertical sync (frame start) |
| cv_in_data | input | PIX*3*BPC | Input pixels, link plane order |
| cv_out_valid | output | 1 | Output beat qualifier |
| cv_out_de | output | 1 | Output active-picture flag |
| cv_out_hsync | output | 1 | Output horizontal sync |
| cv_out_vsync | output | 1 | Output vertical sync |
| cv_out_data | output | PIX*3*BPC | Output pixels, pipeline plane order |
| infoframe | input | 112 | Received AVI InfoFrame, checksum in [7:0] |
| gcp | input | GCP_W | Received General Control Packet |
| tmds_ratio | input | 1 | Link bit-clock ratio flag (high above 3.4 Gbps) |
| xcvr_busy | input | 1 | Transceiver reconfiguration in progress |
| xcvr_rst | output | 1 | Receive transceiver reset |
| rcfg_en | output | 1 | Reconfiguration enable |
| rcfg_chan | output | CHAN_W | Channel that new transceiver settings apply to |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data |

## Verification
The bench builds the block with two pixels per beat at ten bits per plane. With that setting, the lane exchange can be checked on a second pixel slot, which a one-pixel build would never exercise. The address width stays at its default of eight bits, so reads can reach words well past the last mapped register, and partial byte offsets can be tried inside a word. Frames are sent with valid gaps, hsync-only beats and a colour-space change partway through a frame, so that the per-frame latching of the order is observable at the output.

// File: rtl/vrx_pkg.sv
package vrx_pkg;

  typedef enum logic {
    ORD_KEEP = 1'b0,
    ORD_SWAP = 1'b1
  } plane_order_e;

  localparam int unsigned IFR_W     = 112;
  localparam int unsigned CS_LSB    = 13;
  localparam int unsigned W_GCP     = 0;
  localparam int unsigned W_IFR_LO  = 1;
  localparam int unsigned W_IFR_HI  = 13;
  localparam int unsigned W_RATIO   = 14;
  localparam int unsigned W_BUSY    = 16;
  localparam int unsigned W_RST     = 17;
  localparam int unsigned W_RCFG    = 18;
  localparam int unsigned W_CHAN    = 19;

  function automatic plane_order_e order_from_cs(input logic [1:0] cs);
    return (cs == 2'b00) ? ORD_SWAP : ORD_KEEP;
  endfunction

endpackage

// File: rtl/vrx_plane_swap.sv
module vrx_plane_swap
  import vrx_pkg::*;
#(
  parameter int unsigned PIX = 1,
  parameter int unsigned BPC = 10,
  localparam int unsigned DW = PIX * 3 * BPC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_de,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic [DW-1:0] in_data,
  input  logic [1:0]    cs,
  output logic          out_valid,
  output logic          out_de,
  output logic          out_hs,
  output logic          out_vs,
  output logic [DW-1:0] out_data
);

  logic         armed;
  plane_order_e held;
  plane_order_e use_ord;
  logic [DW-1:0] swz;

  // fresh order only on the opening active beat of a frame
  always_comb
    use_ord = (armed && in_valid && in_de) ? order_from_cs(cs) : held;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b1;
      held  <= ORD_SWAP;
    end else if (in_valid) begin
      if (in_vs) begin
        armed <= 1'b1;
      end else if (armed && in_de) begin
        armed <= 1'b0;
        held  <= use_ord;
      end
    end
  end

  for (genvar p = 0; p < PIX; p++) begin : g_pix
    localparam int unsigned B = p * 3 * BPC;
    always_comb begin
      if (use_ord == ORD_SWAP) begin
        swz[B +: BPC]         = in_data[B + BPC +: BPC];
        swz[B + BPC +: BPC]   = in_data[B +: BPC];
      end else begin
        swz[B +: BPC]         = in_data[B +: BPC];
        swz[B + BPC +: BPC]   = in_data[B + BPC +: BPC];
      end
      swz[B + 2*BPC +: BPC] = in_data[B + 2*BPC +: BPC];
    end
  end

  // single aligned stage; no reset needed on the data path
  always_ff @(posedge clk) begin
    out_valid <= in_valid;
    out_de    <= in_de;
    out_hs    <= in_hs;
    out_vs    <= in_vs;
    out_data  <= swz;
  end

  p_pipe_align_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid == $past(in_valid)) && (out_de == $past(in_de)) &&
             (out_hs == $past(in_hs)) && (out_vs == $past(in_vs)));

  p_lane_exchange_r2: assert property (@(posedge clk) disable iff (rst)
    (use_ord == ORD_SWAP) |=> (out_data[BPC-1:0] == $past(in_data[2*BPC-1:BPC])));

  p_lane_keep_r3: assert property (@(posedge clk) disable iff (rst)
    (use_ord == ORD_KEEP) |=> (out_data == $past(in_data)));

  p_frame_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!armed && !(in_valid && in_vs)) |=> $stable(held));

endmodule

// File: rtl/vrx_regbank.sv
module vrx_regbank
  import vrx_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned GCP_W  = 6,
  parameter int unsigned CHAN_W = 4,
  localparam int unsigned WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [31:0]       wdata,
  input  logic              rd,
  output logic [31:0]       rdata,
  input  logic [GCP_W-1:0]  gcp,
  input  logic [IFR_W-1:0]  ifr,
  input  logic              ratio,
  input  logic              busy,
  output logic              xcvr_rst,
  output logic              rcfg_en,
  output logic [CHAN_W-1:0] rcfg_chan
);

  localparam logic [WORD_W-1:0] A_GCP   = WORD_W'(W_GCP);
  localparam logic [WORD_W-1:0] A_RATIO = WORD_W'(W_RATIO);
  localparam logic [WORD_W-1:0] A_BUSY  = WORD_W'(W_BUSY);
  localparam logic [WORD_W-1:0] A_RST   = WORD_W'(W_RST);
  localparam logic [WORD_W-1:0] A_RCFG  = WORD_W'(W_RCFG);
  localparam logic [WORD_W-1:0] A_CHAN  = WORD_W'(W_CHAN);

  logic [WORD_W-1:0] word;
  logic [31:0]       mux;

  assign word = addr[ADDR_W-1:2];

  always_comb begin
    mux = '0;
    for (int k = W_IFR_LO; k <= W_IFR_HI; k++)
      if (word == WORD_W'(k)) mux = {24'b0, ifr[8*k +: 8]};
    case (word)
      A_GCP:   mux = {{(32-GCP_W){1'b0}}, gcp};
      A_RATIO: mux = {31'b0, ratio};
      A_BUSY:  mux = {31'b0, busy};
      A_RST:   mux = {31'b0, xcvr_rst};
      A_RCFG:  mux = {31'b0, rcfg_en};
      A_CHAN:  mux = {{(32-CHAN_W){1'b0}}, rcfg_chan};
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xcvr_rst  <= 1'b0;
      rcfg_en   <= 1'b0;
      rcfg_chan <= '0;
      rdata     <= '0;
    end else begin
      if (wr) begin
        case (word)
          A_RST:   xcvr_rst  <= wdata[0];
          A_RCFG:  rcfg_en   <= wdata[0];
          A_CHAN:  rcfg_chan <= wdata[CHAN_W-1:0];
          default: ;
        endcase
      end
      if (rd) rdata <= mux;
    end
  end

  p_ctrl_write_r8: assert property (@(posedge clk) disable iff (rst)
    (wr && word == A_RST) |=> (xcvr_rst == $past(wdata[0])));

  p_ro_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (wr && word != A_RST && word != A_RCFG && word != A_CHAN) |=>
      ($stable(xcvr_rst) && $stable(rcfg_en) && $stable(rcfg_chan)));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd && word > A_CHAN) |=> (rdata == 32'b0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(rdata));

endmodule

// File: rtl/vrx_adapter.sv
module vrx_adapter
  import vrx_pkg::*;
#(
  parameter int unsigned PIX    = 1,
  parameter int unsigned BPC    = 10,
  parameter int unsigned GCP_W  = 6,
  parameter int unsigned CHAN_W = 4,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned DW = PIX * 3 * BPC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cv_in_valid,
  input  logic              cv_in_de,
  input  logic              cv_in_hsync,
  input  logic              cv_in_vsync,
  input  logic [DW-1:0]     cv_in_data,
  output logic              cv_out_valid,
  output logic              cv_out_de,
  output logic              cv_out_hsync,
  output logic              cv_out_vsync,
  output logic [DW-1:0]     cv_out_data,
  input  logic [111:0]      infoframe,
  input  logic [GCP_W-1:0]  gcp,
  input  logic              tmds_ratio,
  input  logic              xcvr_busy,
  output logic              xcvr_rst,
  output logic              rcfg_en,
  output logic [CHAN_W-1:0] rcfg_chan,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              reg_rd,
  output logic [31:0]       reg_rdata
);

  vrx_plane_swap #(.PIX(PIX), .BPC(BPC)) u_swap (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (cv_in_valid),
    .in_de     (cv_in_de),
    .in_hs     (cv_in_hsync),
    .in_vs     (cv_in_vsync),
    .in_data   (cv_in_data),
    .cs        (infoframe[CS_LSB +: 2]),
    .out_valid (cv_out_valid),
    .out_de    (cv_out_de),
    .out_hs    (cv_out_hsync),
    .out_vs    (cv_out_vsync),
    .out_data  (cv_out_data)
  );

  vrx_regbank #(.ADDR_W(ADDR_W), .GCP_W(GCP_W), .CHAN_W(CHAN_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .addr      (reg_addr),
    .wr        (reg_wr),
    .wdata     (reg_wdata),
    .rd        (reg_rd),
    .rdata     (reg_rdata),
    .gcp       (gcp),
    .ifr       (infoframe),
    .ratio     (tmds_ratio),
    .busy      (xcvr_busy),
    .xcvr_rst  (xcvr_rst),
    .rcfg_en   (rcfg_en),
    .rcfg_chan (rcfg_chan)
  );

endmodule

// File: tb/vrx_adapter_tb.sv
module vrx_adapter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int PIX = 2;
  localparam int BPC = 10;
  localparam int DW  = PIX * 3 * BPC;
  localparam int GCP_W = 6;
  localparam int CHAN_W = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iv = 0, ide = 0, ihs = 0, ivs = 0;
  logic [DW-1:0] idata = '0;
  logic ov, ode, ohs, ovs;
  logic [DW-1:0] odata;
  logic [111:0] ifr = '0;
  logic [GCP_W-1:0] gcp = '0;
  logic ratio = 0, busy = 0;
  logic xrst, ren;
  logic [CHAN_W-1:0] rchan;
  logic [ADDR_W-1:0] addr = '0;
  logic wr = 0, rd = 0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vrx_adapter #(.PIX(PIX), .BPC(BPC), .GCP_W(GCP_W), .CHAN_W(CHAN_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst),
    .cv_in_valid(iv), .cv_in_de(ide), .cv_in_hsync(ihs), .cv_in_vsync(ivs), .cv_in_data(idata),
    .cv_out_valid(ov), .cv_out_de(ode), .cv_out_hsync(ohs), .cv_out_vsync(ovs), .cv_out_data(odata),
    .infoframe(ifr), .gcp(gcp), .tmds_ratio(ratio), .xcvr_busy(busy),
    .xcvr_rst(xrst), .rcfg_en(ren), .rcfg_chan(rchan),
    .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata), .reg_rd(rd), .reg_rdata(rdata)
  );

  typedef struct {
    logic [3:0]    flags;
    logic [DW-1:0] data;
    string         tag;
  } beat_t;

  beat_t sb[$];

  // bench model of the per-frame order choice
  bit m_armed = 1;
  bit m_swap  = 1;

  function automatic logic [DW-1:0] mk(int seed);
    logic [DW-1:0] d;
    for (int p = 0; p < PIX; p++)
      for (int l = 0; l < 3; l++)
        d[(p*3+l)*BPC +: BPC] = BPC'(seed*13 + p*3 + l + 1);
    return d;
  endfunction

  function automatic logic [DW-1:0] exch(logic [DW-1:0] d);
    logic [DW-1:0] r;
    for (int p = 0; p < PIX; p++) begin
      r[(p*3)*BPC +: BPC]   = d[(p*3+1)*BPC +: BPC];
      r[(p*3+1)*BPC +: BPC] = d[(p*3)*BPC +: BPC];
      r[(p*3+2)*BPC +: BPC] = d[(p*3+2)*BPC +: BPC];
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic beat(bit v, bit de, bit hs, bit vs, int seed, string tag);
    beat_t e;
    bit use_swap;
    logic [DW-1:0] d;
    @(negedge clk);
    d = mk(seed);
    use_swap = (v && de && m_armed) ? (ifr[14:13] == 2'b00) : m_swap;
    if (v) begin
      if (vs) m_armed = 1;
      else if (m_armed && de) begin m_armed = 0; m_swap = use_swap; end
    end
    e.flags = {v, de, hs, vs};
    e.data  = use_swap ? exch(d) : d;
    e.tag   = tag;
    sb.push_back(e);
    iv = v; ide = de; ihs = hs; ivs = vs; idata = d;
  endtask

  // monitor: output of a beat appears at the edge after it is driven
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      beat_t e;
      e = sb.pop_front();
      total++;
      if ({ov, ode, ohs, ovs} !== e.flags || odata !== e.data) begin
        bad++;
        $display("FAIL %s: actual=%b/%h expected=%b/%h", e.tag,
                 {ov, ode, ohs, ovs}, odata, e.flags, e.data);
      end
    end
  end

  task automatic rreg(int byte_addr, logic [31:0] exp, string tag);
    @(negedge clk);
    addr = ADDR_W'(byte_addr); rd = 1;
    @(negedge clk);
    rd = 0;
    check(tag, rdata, exp);
  endtask

  task automatic wreg(int byte_addr, logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(byte_addr); wdata = d; wr = 1;
    @(negedge clk);
    wr = 0;
  endtask

  task automatic frame(int base, int n, string tag);
    beat(1, 0, 0, 1, base, "R1");
    beat(1, 0, 1, 0, base + 1, "R1");
    for (int i = 0; i < n; i++) beat(1, 1, 0, 0, base + 2 + i, tag);
  endtask

  initial begin
    for (int k = 0; k < 14; k++) ifr[8*k +: 8] = 8'(8'h10 + k);
    ifr[7:0] = 8'hA5;
    ifr[14:13] = 2'b00;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R8 reset xcvr_rst", {31'b0, xrst}, 0);
    check("R8 reset rcfg_en", {31'b0, ren}, 0);
    check("R8 reset rcfg_chan", {28'b0, rchan}, 0);
    check("R10 reset rdata", rdata, 0);

    // frame with RGB, then colour space changes mid-frame (R4)
    frame(10, 3, "R2");
    ifr[14:13] = 2'b01;
    beat(0, 1, 0, 0, 40, "R1");
    beat(1, 1, 0, 0, 41, "R4");
    beat(1, 0, 1, 0, 42, "R1");
    beat(1, 1, 0, 0, 43, "R4");
    frame(50, 3, "R3");
    ifr[14:13] = 2'b10;
    frame(60, 2, "R3");
    ifr[14:13] = 2'b11;
    frame(70, 2, "R3");
    ifr[14:13] = 2'b00;
    beat(1, 1, 0, 0, 80, "R4");
    frame(90, 4, "R2");
    beat(0, 0, 0, 0, 0, "R1");
    @(negedge clk); @(negedge clk);
    iv = 0; ide = 0;

    // register bank
    gcp = 6'h2B;
    rreg(0, 32'h2B, "R5");
    for (int n = 1; n <= 13; n++) rreg(4*n, 32'(ifr[8*n +: 8]), "R6");
    rreg(4*3 + 2, 32'(ifr[31:24]), "R9 low addr bits");
    ratio = 1; busy = 1;
    rreg(56, 1, "R7 ratio");
    rreg(60, 0, "R7 word15");
    rreg(64, 1, "R7 busy");
    ratio = 0; busy = 0;
    rreg(56, 0, "R7 ratio low");
    rreg(64, 0, "R7 busy low");
    rreg(80, 0, "R9 unmapped");
    rreg(252, 0, "R9 unmapped top");
    wreg(68, 1);
    check("R8 xcvr_rst", {31'b0, xrst}, 1);
    wreg(72, 1);
    check("R8 rcfg_en", {31'b0, ren}, 1);
    wreg(76, 32'hFFF7);
    check("R8 rcfg_chan", {28'b0, rchan}, 7);
    rreg(68, 1, "R8 readback rst");
    rreg(76, 7, "R8 readback chan");
    wreg(20, 32'hFFFF_FFFF);
    rreg(20, 32'(ifr[47:40]), "R9 ro write");
    wreg(56, 32'hFFFF_FFFF);
    rreg(56, 0, "R9 ro ratio");
    wreg(80, 0);
    check("R9 outputs kept", {29'b0, xrst, ren, 1'b0} | {28'b0, rchan}, 32'h7 | 32'h6);
    wreg(68, 0);
    check("R8 xcvr_rst clear", {31'b0, xrst}, 0);
    rreg(0, 32'h2B, "R10 load");
    gcp = 6'h11;
    @(negedge clk); @(negedge clk);
    check("R10 hold", rdata, 32'h2B);
    rreg(0, 32'h11, "R10 reload");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule